// File: doc/BRIEF.md
# Wide-Bus Multi-Packet CRC-32 Engine

This block computes the Ethernet frame check value for every packet that crosses a 1024-bit data path, and keeps up with one bus word per clock. Packets of 64 to 9600 bytes are packed into the bus with any byte alignment. A single word can therefore hold the tail of one packet, the head of the next, and a complete 64-byte packet.

The bus is cut into two 64-byte sections. Each section has its own CRC unit. That unit works out, independently of the other sections, two partial remainders: one for the part of its section that continues an earlier packet, and one for the part that starts a new packet. A merge stage then joins these partials, in wire order, with the remainder carried over from earlier words. It reports each finished packet in the result slot of the section where the packet ended.

Both the input and the output are valid/ready streams that share one stall. `in_ready` equals `out_ready`. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. While `out_ready` is low, the whole pipeline holds its state, and the result slots keep their values and valid flags unchanged. When `out_ready` is high, the slots present on that edge are consumed.

Top module: `wide_crc_engine`

## Requirements
- R1: Each reported value is the Ethernet FCS of its packet, computed as follows. The register starts at all ones. The reflected polynomial 0xEDB88320 is used. Bits are fed least significant first. The register is complemented at the end. Byte b of the bus is `in_data[8b+7:8b]`, and lower byte indices come earlier on the wire.
- R2: Section k covers bus bytes 64k to 64k+63. `in_sop[k]` and `in_eop[k]` flag a packet start and a packet end inside section k. The positions of those bytes are given as 6-bit offsets within the section, in `in_sop_pos[6k+5:6k]` and `in_eop_pos[6k+5:6k]`. The end offset is the last byte of the packet.
- R3: A packet that spans many words has its CRC state carried from section to section and from word to word, and is reported once, at its end.
- R4: A section may hold an end at offset e and a start at offset s, with e < s. Both packets are then computed correctly, including when s = e+1.
- R5: When two packets end in one word, the packet ending in section 0 is reported on slot 0 (`out_crc[31:0]`, `out_valid[0]`), and the packet ending in section 1 is reported on slot 1 (`out_crc[63:32]`, `out_valid[1]`). Results come out in packet order.
- R6: A 64-byte packet that fills one section exactly (start offset 0, end offset 63) is reported from that section alone.
- R7: Bytes that lie between the end of one packet and the start of the next have no effect on any result.
- R8: The result for a word accepted on clock edge n appears on the outputs after edge n+1.
- R9: While `out_ready` is low, `in_ready` is low, and `out_valid` and `out_crc` hold their values.
- R10: Reset clears all result flags and drops any packet still open. After reset, a word without a start flag produces no result.
- R11: A cycle with `in_valid` low changes no state, whatever its data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted on this edge when high |
| in_data | input | 1024 | Bus word, byte 0 in the low bits |
| in_sop | input | 2 | Packet start present, one bit per section |
| in_eop | input | 2 | Packet end present, one bit per section |
| in_sop_pos | input | 12 | Start byte offset, 6 bits per section |
| in_eop_pos | input | 12 | Last byte offset, 6 bits per section |
| out_valid | output | 2 | Result present, one bit per slot |
| out_ready | input | 1 | Downstream accepts results; also stalls the pipeline |
| out_crc | output | 64 | Finished CRC values, 32 bits per slot |

## Verification
The hardest case to reach is a section that closes one packet and opens the next. The two may be separated by garbage bytes or may touch, and this case may fall in the same word as an aligned 64-byte packet, while the output is stalled with two results waiting. A table of packet lengths and gaps is laid out so that these boundaries land on known offsets in known sections. Random streams then add gaps, idle bubbles carrying garbage flags, and random back-pressure. Every result is compared against a bit-serial model that uses the unreflected polynomial.

// File: rtl/wcrc_pkg.sv
package wcrc_pkg;
  localparam int          CRC_W      = 32;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  // One byte through the reflected CRC-32 register, LSB first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/wcrc_section.sv
module wcrc_section
  import wcrc_pkg::*;
#(
  parameter int SEC_BYTES = 64,
  parameter int POS_W     = $clog2(SEC_BYTES),
  parameter int LEN_W     = POS_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   in_valid,
  input  logic [SEC_BYTES*8-1:0] data,
  input  logic                   sop,
  input  logic                   eop,
  input  logic [POS_W-1:0]       sop_pos,
  input  logic [POS_W-1:0]       eop_pos,
  output logic [CRC_W-1:0]       q_tail_part,
  output logic [CRC_W-1:0]       q_head_state,
  output logic [LEN_W-1:0]       q_tail_len,
  output logic                   q_tail_use,
  output logic                   q_tail_end,
  output logic                   q_head,
  output logic                   q_whole
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SEC_BYTES - 1);

  logic             whole, tail_end, tail_use;
  logic [POS_W-1:0] e_lim, h_lim;
  logic [CRC_W-1:0] part_a, part_b;
  logic [LEN_W-1:0] tail_len;

  assign whole    = sop && eop && (sop_pos <= eop_pos);
  assign tail_end = eop && !whole;
  assign tail_use = !sop || tail_end;
  assign e_lim    = tail_end ? eop_pos : LAST;
  assign h_lim    = whole ? eop_pos : LAST;
  assign tail_len = LEN_W'(e_lim) + LEN_W'(1);

  // Tail partial starts from zero so the carried state can be folded in later;
  // head state starts from the seed since a new packet needs nothing earlier.
  always_comb begin
    part_a = '0;
    part_b = CRC_SEED;
    for (int j = 0; j < SEC_BYTES; j++) begin
      if (j <= int'(e_lim))
        part_a = crc_byte(part_a, data[8*j +: 8]);
      if (j >= int'(sop_pos) && j <= int'(h_lim))
        part_b = crc_byte(part_b, data[8*j +: 8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_tail_part  <= '0;
      q_head_state <= '0;
      q_tail_len   <= '0;
      q_tail_use   <= 1'b0;
      q_tail_end   <= 1'b0;
      q_head       <= 1'b0;
      q_whole      <= 1'b0;
    end else if (en) begin
      q_tail_part  <= part_a;
      q_head_state <= part_b;
      q_tail_len   <= tail_len;
      q_tail_use   <= tail_use;
      q_tail_end   <= tail_end;
      q_head       <= sop;
      q_whole      <= whole;
    end
  end

  // R6
  short_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid && sop && eop && (sop_pos <= eop_pos)) |-> (sop_pos == '0 && eop_pos == LAST));
endmodule

// File: rtl/wcrc_merge.sv
module wcrc_merge
  import wcrc_pkg::*;
#(
  parameter int SECTIONS  = 2,
  parameter int SEC_BYTES = 64,
  parameter int LEN_W     = $clog2(SEC_BYTES) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      s_valid,
  input  logic [SECTIONS*CRC_W-1:0] s_tail_part,
  input  logic [SECTIONS*CRC_W-1:0] s_head_state,
  input  logic [SECTIONS*LEN_W-1:0] s_tail_len,
  input  logic [SECTIONS-1:0]       s_tail_use,
  input  logic [SECTIONS-1:0]       s_tail_end,
  input  logic [SECTIONS-1:0]       s_head,
  input  logic [SECTIONS-1:0]       s_whole,
  output logic [SECTIONS-1:0]       res_valid,
  output logic [SECTIONS*CRC_W-1:0] res_crc
);
  logic [CRC_W-1:0]          carry_q, st;
  logic                      open_q, opn;
  logic [SECTIONS-1:0]       done;
  logic [SECTIONS*CRC_W-1:0] crcs;

  // Push a state through n zero bytes (linear part of a section pass).
  function automatic logic [CRC_W-1:0] advance(input logic [CRC_W-1:0] c, input logic [LEN_W-1:0] n);
    logic [CRC_W-1:0] r;
    r = c;
    for (int j = 0; j < SEC_BYTES; j++)
      if (j < int'(n)) r = crc_byte(r, 8'h00);
    return r;
  endfunction

  always_comb begin
    st   = carry_q;
    opn  = open_q;
    done = '0;
    crcs = '0;
    for (int k = 0; k < SECTIONS; k++) begin
      if (s_valid) begin
        if (opn && s_tail_use[k]) begin
          st = advance(st, s_tail_len[k*LEN_W +: LEN_W]) ^ s_tail_part[k*CRC_W +: CRC_W];
          if (s_tail_end[k]) begin
            done[k] = 1'b1;
            crcs[k*CRC_W +: CRC_W] = ~st;
            opn = 1'b0;
          end
        end
        if (s_head[k]) begin
          if (s_whole[k]) begin
            done[k] = 1'b1;
            crcs[k*CRC_W +: CRC_W] = ~s_head_state[k*CRC_W +: CRC_W];
          end else begin
            st  = s_head_state[k*CRC_W +: CRC_W];
            opn = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q   <= '0;
      open_q    <= 1'b0;
      res_valid <= '0;
      res_crc   <= '0;
    end else if (en) begin
      carry_q   <= st;
      open_q    <= opn;
      res_valid <= done;
      res_crc   <= crcs;
    end
  end

  // R6
  whole_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s_valid && (|s_whole)) |=> (|res_valid));

  // R4
  eop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s_valid && s_tail_end[0]) |-> open_q);
endmodule

// File: rtl/wide_crc_engine.sv
module wide_crc_engine
  import wcrc_pkg::*;
#(
  parameter int SECTIONS  = 2,
  parameter int SEC_BYTES = 64,
  parameter int POS_W     = $clog2(SEC_BYTES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [SECTIONS*SEC_BYTES*8-1:0]   in_data,
  input  logic [SECTIONS-1:0]               in_sop,
  input  logic [SECTIONS-1:0]               in_eop,
  input  logic [SECTIONS*POS_W-1:0]         in_sop_pos,
  input  logic [SECTIONS*POS_W-1:0]         in_eop_pos,
  output logic [SECTIONS-1:0]               out_valid,
  input  logic                              out_ready,
  output logic [SECTIONS*32-1:0]            out_crc
);
  localparam int SEC_BITS = SEC_BYTES * 8;
  localparam int LEN_W    = POS_W + 1;

  logic                      en, s1_valid;
  logic [SECTIONS*CRC_W-1:0] tail_part, head_state;
  logic [SECTIONS*LEN_W-1:0] tail_len;
  logic [SECTIONS-1:0]       tail_use, tail_end, head, whole;

  assign en       = out_ready;
  assign in_ready = out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  s1_valid <= 1'b0;
    else if (en) s1_valid <= in_valid;
  end

  for (genvar k = 0; k < SECTIONS; k++) begin : g_sec
    wcrc_section #(.SEC_BYTES(SEC_BYTES), .POS_W(POS_W), .LEN_W(LEN_W)) u_sec (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .in_valid     (in_valid),
      .data         (in_data[k*SEC_BITS +: SEC_BITS]),
      .sop          (in_sop[k]),
      .eop          (in_eop[k]),
      .sop_pos      (in_sop_pos[k*POS_W +: POS_W]),
      .eop_pos      (in_eop_pos[k*POS_W +: POS_W]),
      .q_tail_part  (tail_part[k*CRC_W +: CRC_W]),
      .q_head_state (head_state[k*CRC_W +: CRC_W]),
      .q_tail_len   (tail_len[k*LEN_W +: LEN_W]),
      .q_tail_use   (tail_use[k]),
      .q_tail_end   (tail_end[k]),
      .q_head       (head[k]),
      .q_whole      (whole[k])
    );
  end

  wcrc_merge #(.SECTIONS(SECTIONS), .SEC_BYTES(SEC_BYTES), .LEN_W(LEN_W)) u_merge (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .s_valid      (s1_valid),
    .s_tail_part  (tail_part),
    .s_head_state (head_state),
    .s_tail_len   (tail_len),
    .s_tail_use   (tail_use),
    .s_tail_end   (tail_end),
    .s_head       (head),
    .s_whole      (whole),
    .res_valid    (out_valid),
    .res_crc      (out_crc)
  );

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_valid) && !out_ready) |=> ($stable(out_valid) && $stable(out_crc)));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0));
endmodule

// File: tb/wide_crc_engine_tb.sv
module wide_crc_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SECTIONS   = 2;
  localparam int SEC_BYTES  = 64;
  localparam int POS_W      = 6;
  localparam int W_BYTES    = SECTIONS * SEC_BYTES;
  localparam int BUS_BITS   = W_BYTES * 8;
  localparam int NTAB       = 16;
  // Packet lengths and leading gaps, laid out so boundaries land on chosen offsets.
  localparam int LENS [NTAB] = '{64, 64, 100, 70, 9600, 65, 127, 128, 129, 191, 1500, 64, 64, 9600, 200, 64};
  localparam int GAPS [NTAB] = '{0,  0,  0,   5,  0,    1,  0,   3,   0,   2,   0,    0,  0,  7,    0,   0};

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       in_valid = 1'b0;
  logic                       in_ready;
  logic [BUS_BITS-1:0]        in_data = '0;
  logic [SECTIONS-1:0]        in_sop = '0, in_eop = '0;
  logic [SECTIONS*POS_W-1:0]  in_sop_pos = '0, in_eop_pos = '0;
  logic [SECTIONS-1:0]        out_valid;
  logic                       out_ready = 1'b1;
  logic [SECTIONS*32-1:0]     out_crc;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";
  logic [7:0]  img[$];
  bit          sop_m[$], eop_m[$];
  logic [31:0] exp_q[$];
  logic        rdy_at_edge = 1'b0;
  logic [SECTIONS-1:0]    pend_v = '0;
  logic [SECTIONS*32-1:0] pend_c = '0;

  wide_crc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_sop_pos(in_sop_pos), .in_eop_pos(in_eop_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_crc(out_crc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bit-serial model, unreflected register, output bit-reversed and complemented.
  function automatic logic [31:0] ref_crc(input int s, input int n);
    logic [31:0] c, r;
    logic [7:0]  b;
    logic        fb;
    c = '1;
    for (int i = 0; i < n; i++) begin
      b = img[s+i];
      for (int t = 0; t < 8; t++) begin
        fb = c[31] ^ b[t];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    for (int t = 0; t < 32; t++) r[t] = c[31-t];
    return ~r;
  endfunction

  task automatic clear_stream();
    img.delete(); sop_m.delete(); eop_m.delete();
  endtask

  task automatic add_packet(input int len, input int gap);
    int st;
    for (int i = 0; i < gap; i++) begin
      img.push_back(8'($urandom)); sop_m.push_back(1'b0); eop_m.push_back(1'b0);
    end
    st = img.size();
    for (int i = 0; i < len; i++) begin
      img.push_back(8'($urandom)); sop_m.push_back(i == 0); eop_m.push_back(i == len-1);
    end
    exp_q.push_back(ref_crc(st, len));
  endtask

  task automatic make_word(input int w, output logic [BUS_BITS-1:0] d, output logic [SECTIONS-1:0] s,
                           output logic [SECTIONS-1:0] e, output logic [SECTIONS*POS_W-1:0] sp,
                           output logic [SECTIONS*POS_W-1:0] ep);
    d = '0; s = '0; e = '0; sp = '0; ep = '0;
    for (int b = 0; b < W_BYTES; b++) begin
      int idx, sec, off;
      idx = w*W_BYTES + b; sec = b / SEC_BYTES; off = b % SEC_BYTES;
      if (idx < img.size()) begin
        d[8*b +: 8] = img[idx];
        if (sop_m[idx]) begin s[sec] = 1'b1; sp[sec*POS_W +: POS_W] = POS_W'(off); end
        if (eop_m[idx]) begin e[sec] = 1'b1; ep[sec*POS_W +: POS_W] = POS_W'(off); end
      end else d[8*b +: 8] = 8'($urandom);
    end
  endtask

  task automatic drive(input logic v, input logic [BUS_BITS-1:0] d, input logic [SECTIONS-1:0] s,
                       input logic [SECTIONS-1:0] e, input logic [SECTIONS*POS_W-1:0] sp,
                       input logic [SECTIONS*POS_W-1:0] ep, input bit stall);
    bit go;
    do begin
      @(negedge clk);
      out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      in_valid = v; in_data = d; in_sop = s; in_eop = e; in_sop_pos = sp; in_eop_pos = ep;
      #1;
      if (stall && !out_ready) check(in_ready == 1'b0, "R9 in_ready low on stall", 64'(in_ready), 64'h0);
      go = in_ready;
    end while (v && !go);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0, '0, '0, '0, 1'b0);
  endtask

  task automatic send_stream(input bit stall, input bit bubbles);
    int nw;
    logic [BUS_BITS-1:0] d;
    logic [SECTIONS-1:0] s, e;
    logic [SECTIONS*POS_W-1:0] sp, ep;
    nw = (img.size() + W_BYTES - 1) / W_BYTES;
    for (int w = 0; w < nw; w++) begin
      if (bubbles && ($urandom % 4 == 0)) begin
        // R11: garbage with random flags while in_valid is low
        drive(1'b0, {32{$urandom}}, 2'($urandom), 2'($urandom), 12'($urandom), 12'($urandom), stall);
      end
      make_word(w, d, s, e, sp, ep);
      drive(1'b1, d, s, e, sp, ep, stall);
    end
    idle(6);
    check(exp_q.size() == 0, {cur_tag, " all results delivered"}, 64'(exp_q.size()), 64'h0);
    exp_q.delete();
  endtask

  always @(posedge clk) rdy_at_edge <= out_ready;

  // Result monitor: a slot is consumed at the edge after it was seen with out_ready high.
  always @(negedge clk) begin
    if (!rst_n) begin
      pend_v = '0;
    end else begin
      if ((pend_v != 0) && rdy_at_edge) begin
        for (int k = 0; k < SECTIONS; k++) if (pend_v[k]) begin
          if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected result"}, 64'(pend_c[k*32 +: 32]), 64'h0);
          else begin
            logic [31:0] ex;
            ex = exp_q.pop_front();
            check(pend_c[k*32 +: 32] == ex, {cur_tag, " CRC value"}, 64'(pend_c[k*32 +: 32]), 64'(ex));
          end
        end
      end else if (pend_v != 0) begin
        check(out_valid == pend_v && out_crc == pend_c, "R9 outputs held on stall",
              64'(out_crc[31:0]), 64'(pend_c[31:0]));
      end
      pend_v = out_valid;
      pend_c = out_crc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [BUS_BITS-1:0] d;
    logic [SECTIONS-1:0] s, e;
    logic [SECTIONS*POS_W-1:0] sp, ep;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid == '0, "R10 out_valid in reset", 64'(out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0, "R10 out_valid after reset", 64'(out_valid), 64'h0);

    // R8: latency of an aligned 64-byte packet (also R6)
    cur_tag = "R6 R8";
    clear_stream(); add_packet(64, 0);
    make_word(0, d, s, e, sp, ep);
    drive(1'b1, d, s, e, sp, ep, 1'b0);
    drive(1'b0, '0, '0, '0, '0, '0, 1'b0);
    check(out_valid == '0, "R8 no result after one edge", 64'(out_valid), 64'h0);
    drive(1'b0, '0, '0, '0, '0, '0, 1'b0);
    check(out_valid == 2'b01, "R8 result after two edges", 64'(out_valid), 64'h1);
    idle(4);
    check(exp_q.size() == 0, "R8 result consumed", 64'(exp_q.size()), 64'h0);
    exp_q.delete();

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    cur_tag = "R1 R2 R3 R4 R5 R6 R7";
    clear_stream();
    for (int i = 0; i < NTAB; i++) add_packet(LENS[i], GAPS[i]);
    send_stream(1'b0, 1'b0);

    // R9 R11: random lengths with back-pressure and idle bubbles
    cur_tag = "R9 R11 R3";
    clear_stream();
    for (int i = 0; i < 12; i++) add_packet(64 + ($urandom % 9537), $urandom % 20);
    send_stream(1'b1, 1'b1);

    // R10: reset in mid-packet drops the open packet
    cur_tag = "R10";
    clear_stream(); add_packet(200, 0); exp_q.delete();
    make_word(0, d, s, e, sp, ep);
    drive(1'b1, d, s, e, sp, ep, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, {32{$urandom}}, '0, '0, '0, '0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, '0, '0, '0, '0, '0, 1'b0);
      check(out_valid == '0, "R10 no result from dropped packet", 64'(out_valid), 64'h0);
    end

    // R1 R4 R5: long random back-to-back stream, no stall
    cur_tag = "R1 R4 R5 R7";
    clear_stream();
    for (int i = 0; i < 20; i++) add_packet(64 + ($urandom % 9537), ($urandom % 3 == 0) ? 0 : $urandom % 70);
    send_stream(1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule